// File: doc/BRIEF.md
# Hit-Way Tag Integrity Checker

This block sits one pipeline stage after a set-associative cache's tag comparison. That comparison has already chosen a hit way using the stored tags without correcting them first. The checker takes the registered tags and stored check bits of every way, together with the raw one-hot hit vector. It routes only the hit way's tag and check bits into one shared decoder. The decoder forms a Hamming position syndrome and an overall parity result.

The decoder only detects errors and never repairs the tag. A flip that lands in the tag itself, or any double error, means the earlier hit cannot be trusted. In that case the lookup is reported as a miss and a one-cycle refill request is raised. A flip that lands only in a stored check bit leaves the tag intact, so the hit stands and only the single-error flag is raised. When no way hit, the raw miss passes through without any check.

All results are registered and appear one clock after a valid lookup is accepted.

Top module: `tag_ecc_check`

## Requirements
- R1: While reset is held and after its release, every output is low until a valid lookup has been accepted.
- R2: The outputs for a lookup accepted on a clock edge (lookupValid high) appear on the next edge with outValid high. A cycle with lookupValid low produces outValid low and all other outputs low one cycle later.
- R3: The codeword places check bit chk[k] (k = 0..4) at Hamming position 2^k, and tag bits 0..25 at the remaining positions 3, 5, 6, 7, 9, ... 31 in ascending order. chk[5] makes the XOR of all 32 bits zero. A clean codeword on a raw hit gives lookupHit=1, hitWay equal to the raw hit vector, and no error flags.
- R4: A single flip in a check bit (chk[0..5]) of the hit way gives singleError=1 and tagError=0, and the hit stands with hitWay unchanged.
- R5: A single flip in any tag bit of the hit way gives singleError=1 and tagError=1, lookupHit=0 and hitWay=0.
- R6: A nonzero position syndrome with correct overall parity (any two flips) gives doubleError=1, tagError=1 and singleError=0, and the lookup becomes a miss.
- R7: Only the hit way is checked: corruption in any other way's tag or check bits has no effect on the outputs.
- R8: With a valid lookup and an all-zero raw hit vector, lookupHit=0, hitWay=0 and tagError, singleError, doubleError and refillReq are all 0, even if the stored data is corrupt.
- R9: refillReq is high for exactly the one output cycle of a raw hit that tagError turned into a miss, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | A lookup is presented this cycle |
| rawHit | input | NWAYS | One-hot (or zero) hit vector from the uncorrected tag compare |
| wayTags | input | NWAYS*TAG_W | Registered stored tags; way w at bits [w*TAG_W +: TAG_W] |
| wayChks | input | NWAYS*CHK_W | Registered stored check bits; way w at bits [w*CHK_W +: CHK_W] |
| outValid | output | 1 | Result of an accepted lookup is present |
| lookupHit | output | 1 | Final hit after the integrity check |
| hitWay | output | NWAYS | One-hot final hit way, zero on a miss |
| tagError | output | 1 | Stored tag of the hit way is untrustworthy |
| singleError | output | 1 | Exactly one bit of the hit way's codeword flipped |
| doubleError | output | 1 | Uncorrectable (double) error in the hit way's codeword |
| refillReq | output | 1 | One-cycle request to fetch the line after a demoted hit |

## Verification
The bench uses the default build of a 26-bit tag over four ways. With these values the Hamming positions run from 1 to 31 and the overall parity bit completes a 32-bit word, so every nonzero syndrome points at a real position. The bench flips every check-bit position and the overall parity bit. It flips tag bits at both ends of the codeword and at interior positions. It also applies double flips that mix tag and check bits. Clean lookups run through each of the four ways, and corruption is planted in ways that did not hit, so the way selection in front of the single decoder is exercised.

// File: rtl/tag_ecc_pkg.sv
`timescale 1ns/1ps
package tag_ecc_pkg;

  // Smallest number of Hamming check bits that can cover a tag of tagW bits.
  function automatic int hamBits(input int tagW);
    int result;
    result = 1;
    for (int q = 1; q < 16; q++) begin
      if (((1 << q) < (tagW + q + 1)) && (result == q)) result = q + 1;
    end
    return result;
  endfunction

  // Control-to-datapath strobes.
  typedef struct packed {
    logic capture;   // a lookup is accepted this cycle
    logic checkOn;   // the accepted lookup has a raw hit and must be checked
  } tchk_strobe_t;

  // Decoder verdict for the selected codeword.
  typedef struct packed {
    logic single;    // one flipped bit anywhere in the codeword
    logic dbl;       // uncorrectable pattern
    logic tagBad;    // the tag bits themselves cannot be trusted
  } tchk_verdict_t;

endpackage

// File: rtl/tag_ecc_ctrl.sv
`timescale 1ns/1ps
module tag_ecc_ctrl
  import tag_ecc_pkg::*;
#(
  parameter int NWAYS = 4
) (
  input  logic             lookupValid,
  input  logic [NWAYS-1:0] rawHit,
  output tchk_strobe_t     strobe
);

  logic anyHit;

  always_comb begin
    anyHit = |rawHit;
    strobe.capture = lookupValid;
    strobe.checkOn = lookupValid & anyHit;
  end

endmodule

// File: rtl/tag_ecc_datapath.sv
`timescale 1ns/1ps
module tag_ecc_datapath
  import tag_ecc_pkg::*;
#(
  parameter int TAG_W = 26,
  parameter int NWAYS = 4,
  localparam int HAM_W = hamBits(TAG_W),
  localparam int CHK_W = HAM_W + 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  tchk_strobe_t           strobe,
  input  logic [NWAYS-1:0]       rawHit,
  input  logic [NWAYS*TAG_W-1:0] wayTags,
  input  logic [NWAYS*CHK_W-1:0] wayChks,
  output logic                   outValid,
  output logic                   lookupHit,
  output logic [NWAYS-1:0]       hitWay,
  output logic                   tagError,
  output logic                   singleError,
  output logic                   doubleError,
  output logic                   refillReq
);

  localparam int NPOS = TAG_W + HAM_W;

  logic [TAG_W-1:0] selTag;
  logic [CHK_W-1:0] selChk;
  logic [NPOS:1]    cw;
  logic [HAM_W-1:0] syn;
  logic             parFail;
  logic             synNz;
  logic             synAtChk;
  logic             synOutRange;
  tchk_verdict_t    verdict;

  // AND-OR selection of the hit way; rawHit is one-hot or zero.
  always_comb begin
    selTag = '0;
    selChk = '0;
    for (int w = 0; w < NWAYS; w++) begin
      selTag = selTag | (wayTags[w*TAG_W +: TAG_W] & {TAG_W{rawHit[w]}});
      selChk = selChk | (wayChks[w*CHK_W +: CHK_W] & {CHK_W{rawHit[w]}});
    end
  end

  // Hamming-ordered codeword: check bits at powers of two, tag bits elsewhere.
  for (genvar pos = 1; pos <= NPOS; pos++) begin : g_pos
    if ((pos & (pos - 1)) == 0) begin : g_chk
      assign cw[pos] = selChk[$clog2(pos)];
    end else begin : g_tag
      assign cw[pos] = selTag[pos - 1 - $clog2(pos + 1)];
    end
  end

  // Position syndrome and overall parity.
  always_comb begin
    syn = '0;
    for (int pos = 1; pos <= NPOS; pos++) begin
      for (int k = 0; k < HAM_W; k++) begin
        if (pos[k]) syn[k] = syn[k] ^ cw[pos];
      end
    end
    parFail = (^cw) ^ selChk[HAM_W];
  end

  // Classification of the syndrome.
  always_comb begin
    synNz       = |syn;
    synAtChk    = $onehot(syn);
    synOutRange = (32'(syn) > NPOS);
    verdict     = '0;
    if (parFail) begin
      if (!synNz || synAtChk) begin
        verdict.single = 1'b1;            // stored check bit flipped, tag intact
      end else if (synOutRange) begin
        verdict.dbl    = 1'b1;            // no such position: multi-bit pattern
        verdict.tagBad = 1'b1;
      end else begin
        verdict.single = 1'b1;            // tag bit flipped
        verdict.tagBad = 1'b1;
      end
    end else if (synNz) begin
      verdict.dbl    = 1'b1;
      verdict.tagBad = 1'b1;
    end
  end

  // Registered results; every output drops when no lookup is accepted.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      lookupHit   <= 1'b0;
      hitWay      <= '0;
      tagError    <= 1'b0;
      singleError <= 1'b0;
      doubleError <= 1'b0;
      refillReq   <= 1'b0;
    end else if (strobe.checkOn) begin
      outValid    <= 1'b1;
      lookupHit   <= ~verdict.tagBad;
      hitWay      <= verdict.tagBad ? '0 : rawHit;
      tagError    <= verdict.tagBad;
      singleError <= verdict.single;
      doubleError <= verdict.dbl;
      refillReq   <= verdict.tagBad;
    end else begin
      outValid    <= strobe.capture;
      lookupHit   <= 1'b0;
      hitWay      <= '0;
      tagError    <= 1'b0;
      singleError <= 1'b0;
      doubleError <= 1'b0;
      refillReq   <= 1'b0;
    end
  end

endmodule

// File: rtl/tag_ecc_check.sv
`timescale 1ns/1ps
module tag_ecc_check
  import tag_ecc_pkg::*;
#(
  parameter int TAG_W = 26,
  parameter int NWAYS = 4,
  localparam int CHK_W = hamBits(TAG_W) + 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   lookupValid,
  input  logic [NWAYS-1:0]       rawHit,
  input  logic [NWAYS*TAG_W-1:0] wayTags,
  input  logic [NWAYS*CHK_W-1:0] wayChks,
  output logic                   outValid,
  output logic                   lookupHit,
  output logic [NWAYS-1:0]       hitWay,
  output logic                   tagError,
  output logic                   singleError,
  output logic                   doubleError,
  output logic                   refillReq
);

  tchk_strobe_t strobe;

  tag_ecc_ctrl #(.NWAYS(NWAYS)) u_ctrl (
    .lookupValid (lookupValid),
    .rawHit      (rawHit),
    .strobe      (strobe)
  );

  tag_ecc_datapath #(.TAG_W(TAG_W), .NWAYS(NWAYS)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .rawHit      (rawHit),
    .wayTags     (wayTags),
    .wayChks     (wayChks),
    .outValid    (outValid),
    .lookupHit   (lookupHit),
    .hitWay      (hitWay),
    .tagError    (tagError),
    .singleError (singleError),
    .doubleError (doubleError),
    .refillReq   (refillReq)
  );

endmodule

// File: rtl/tag_ecc_check_sva.sv
`timescale 1ns/1ps
module tag_ecc_check_sva #(
  parameter int NWAYS = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             lookupValid,
  input logic [NWAYS-1:0] rawHit,
  input logic             outValid,
  input logic             lookupHit,
  input logic [NWAYS-1:0] hitWay,
  input logic             tagError,
  input logic             singleError,
  input logic             doubleError,
  input logic             refillReq
);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(lookupValid));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!lookupHit && hitWay == '0 && !tagError && !refillReq));

  a_r4_check_flip_keeps_hit: assert property (@(posedge clk) disable iff (!rstN)
    (singleError && !tagError) |-> lookupHit);

  a_r6_double_is_tag_error: assert property (@(posedge clk) disable iff (!rstN)
    doubleError |-> (tagError && !singleError));

  a_r5_tag_error_is_miss: assert property (@(posedge clk) disable iff (!rstN)
    tagError |-> (!lookupHit && hitWay == '0));

  a_r8_error_needs_hit: assert property (@(posedge clk) disable iff (!rstN)
    tagError |-> $past(lookupValid && (|rawHit)));

  a_r3_hit_way_from_raw: assert property (@(posedge clk) disable iff (!rstN)
    lookupHit |-> ($onehot(hitWay) && hitWay == $past(rawHit)));

  a_r9_refill_on_demoted_hit: assert property (@(posedge clk) disable iff (!rstN)
    refillReq == (outValid && tagError));

endmodule

bind tag_ecc_check tag_ecc_check_sva #(.NWAYS(NWAYS)) u_sva (
  .clk         (clk),
  .rstN        (rstN),
  .lookupValid (lookupValid),
  .rawHit      (rawHit),
  .outValid    (outValid),
  .lookupHit   (lookupHit),
  .hitWay      (hitWay),
  .tagError    (tagError),
  .singleError (singleError),
  .doubleError (doubleError),
  .refillReq   (refillReq)
);

// File: tb/test_tag_ecc_check.sv
`timescale 1ns/1ps
module test_tag_ecc_check;

  localparam int TAG_W = 26;
  localparam int NWAYS = 4;
  localparam int HAM_W = 5;
  localparam int CHK_W = 6;
  localparam int NPOS  = 31;

  logic                   clk = 1'b0;
  logic                   rstN = 1'b0;
  logic                   lookupValid = 1'b0;
  logic [NWAYS-1:0]       rawHit = '0;
  logic [NWAYS*TAG_W-1:0] wayTags = '0;
  logic [NWAYS*CHK_W-1:0] wayChks = '0;
  logic                   outValid, lookupHit, tagError, singleError, doubleError, refillReq;
  logic [NWAYS-1:0]       hitWay;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  tag_ecc_check #(.TAG_W(TAG_W), .NWAYS(NWAYS)) i_tag_ecc_check (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .rawHit(rawHit),
    .wayTags(wayTags), .wayChks(wayChks), .outValid(outValid),
    .lookupHit(lookupHit), .hitWay(hitWay), .tagError(tagError),
    .singleError(singleError), .doubleError(doubleError), .refillReq(refillReq)
  );

  function automatic bit isPow2(input int v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

  // Encoder built from R3: tag bits at non-power-of-two positions in order.
  function automatic logic [CHK_W-1:0] encode(input logic [TAG_W-1:0] t);
    logic [NPOS:1] w;
    logic [CHK_W-1:0] c;
    int ti;
    w = '0; c = '0; ti = 0;
    for (int pos = 1; pos <= NPOS; pos++) begin
      if (!isPow2(pos)) begin w[pos] = t[ti]; ti++; end
    end
    for (int k = 0; k < HAM_W; k++) begin
      for (int pos = 1; pos <= NPOS; pos++) begin
        if (((pos >> k) & 1) == 1) c[k] = c[k] ^ w[pos];
      end
      w[1 << k] = c[k];
    end
    c[HAM_W] = ^w;
    return c;
  endfunction

  // Flip codeword position pos of {tag,chk}; pos 0 means the overall bit.
  function automatic logic [TAG_W+CHK_W-1:0] flipAt(input logic [TAG_W-1:0] t,
                                                    input logic [CHK_W-1:0] c,
                                                    input int pos);
    int ti;
    if (pos == 0) c[HAM_W] = ~c[HAM_W];
    else if (isPow2(pos)) begin
      for (int k = 0; k < HAM_W; k++) if ((1 << k) == pos) c[k] = ~c[k];
    end else begin
      ti = 0;
      for (int p = 1; p < pos; p++) if (!isPow2(p)) ti++;
      t[ti] = ~t[ti];
    end
    return {t, c};
  endfunction

  // Load clean, distinct contents into all ways.
  task automatic loadClean(input logic [TAG_W-1:0] seed);
    for (int w = 0; w < NWAYS; w++) begin
      logic [TAG_W-1:0] t;
      t = seed ^ TAG_W'(32'h1F3A5C7 * (w + 1));
      wayTags[w*TAG_W +: TAG_W] = t;
      wayChks[w*CHK_W +: CHK_W] = encode(t);
    end
  endtask

  task automatic corrupt(input int way, input int pos);
    logic [TAG_W+CHK_W-1:0] r;
    r = flipAt(wayTags[way*TAG_W +: TAG_W], wayChks[way*CHK_W +: CHK_W], pos);
    wayTags[way*TAG_W +: TAG_W] = r[TAG_W+CHK_W-1:CHK_W];
    wayChks[way*CHK_W +: CHK_W] = r[CHK_W-1:0];
  endtask

  task automatic expectOut(input string req, input logic v, input logic h,
                           input logic [NWAYS-1:0] w, input logic te,
                           input logic se, input logic de, input logic rf);
    logic [NWAYS+5:0] act, exp;
    act = {outValid, lookupHit, hitWay, tagError, singleError, doubleError, refillReq};
    exp = {v, h, w, te, se, de, rf};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b (valid,hit,way,tagErr,single,double,refill)",
               req, act, exp);
    end
  endtask

  // Present one lookup at a falling edge, sample one cycle later.
  task automatic lookup(input logic [NWAYS-1:0] hit);
    @(negedge clk);
    lookupValid = 1'b1;
    rawHit = hit;
    @(negedge clk);
    lookupValid = 1'b0;
    rawHit = '0;
  endtask

  task automatic t_reset;
    rstN = 1'b0;
    lookupValid = 1'b1; rawHit = 4'b0001;
    repeat (3) @(negedge clk);
    expectOut("R1 in reset", 0, 0, '0, 0, 0, 0, 0);
    lookupValid = 1'b0; rawHit = '0;
    rstN = 1'b1;
    @(negedge clk);
    expectOut("R1 after release", 0, 0, '0, 0, 0, 0, 0);
  endtask

  task automatic t_clean;
    for (int w = 0; w < NWAYS; w++) begin
      loadClean(TAG_W'(32'h2A5F00D ^ (w * 32'h111)));
      lookup(NWAYS'(1 << w));
      expectOut("R3 clean hit", 1, 1, NWAYS'(1 << w), 0, 0, 0, 0);
    end
    loadClean('1);
    lookup(4'b0100);
    expectOut("R3 all-ones seed", 1, 1, 4'b0100, 0, 0, 0, 0);
  endtask

  task automatic t_latency;
    loadClean(26'h0ABCDEF);
    @(negedge clk);
    lookupValid = 1'b1; rawHit = 4'b0010;
    #1;
    expectOut("R2 not before edge", 0, 0, '0, 0, 0, 0, 0);
    @(negedge clk);
    lookupValid = 1'b0; rawHit = '0;
    expectOut("R2 one cycle later", 1, 1, 4'b0010, 0, 0, 0, 0);
    @(negedge clk);
    expectOut("R2 idle cycle", 0, 0, '0, 0, 0, 0, 0);
  endtask

  task automatic t_check_flips;
    int cpos[6] = '{1, 2, 4, 8, 16, 0};
    foreach (cpos[i]) begin
      loadClean(26'h1234567);
      corrupt(2, cpos[i]);
      lookup(4'b0100);
      expectOut("R4 check-bit flip", 1, 1, 4'b0100, 0, 1, 0, 0);
    end
  endtask

  task automatic t_tag_flips;
    int tpos[5] = '{3, 5, 17, 30, 31};
    foreach (tpos[i]) begin
      loadClean(26'h3C3C3C3);
      corrupt(1, tpos[i]);
      lookup(4'b0010);
      expectOut("R5 tag-bit flip", 1, 0, '0, 1, 1, 0, 1);
      @(negedge clk);
      expectOut("R9 refill one cycle", 0, 0, '0, 0, 0, 0, 0);
    end
  endtask

  task automatic t_double;
    int pa[4] = '{3, 1, 1, 2};
    int pb[4] = '{31, 12, 0, 16};
    foreach (pa[i]) begin
      loadClean(26'h2AAAAAA);
      corrupt(3, pa[i]);
      corrupt(3, pb[i]);
      lookup(4'b1000);
      expectOut("R6 double flip", 1, 0, '0, 1, 0, 1, 1);
    end
  endtask

  task automatic t_other_ways;
    loadClean(26'h0F0F0F0);
    corrupt(0, 7);
    corrupt(1, 1); corrupt(1, 9);
    corrupt(3, 0);
    lookup(4'b0100);
    expectOut("R7 other ways corrupt", 1, 1, 4'b0100, 0, 0, 0, 0);
  endtask

  task automatic t_miss;
    loadClean(26'h1555555);
    corrupt(0, 5); corrupt(1, 6); corrupt(2, 3); corrupt(2, 4); corrupt(3, 0);
    lookup('0);
    expectOut("R8 raw miss passes", 1, 0, '0, 0, 0, 0, 0);
  endtask

  task automatic t_back_to_back;
    loadClean(26'h0777777);
    corrupt(0, 11);
    @(negedge clk);
    lookupValid = 1'b1; rawHit = 4'b0001;
    @(negedge clk);
    expectOut("R9 demoted hit", 1, 0, '0, 1, 1, 0, 1);
    rawHit = 4'b0010;
    @(negedge clk);
    lookupValid = 1'b0; rawHit = '0;
    expectOut("R9 clean follow-up no refill", 1, 1, 4'b0010, 0, 0, 0, 0);
  endtask

  initial begin
    t_reset();
    t_clean();
    t_latency();
    t_check_flips();
    t_tag_flips();
    t_double();
    t_other_ways();
    t_miss();
    t_back_to_back();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule